// File: doc/BRIEF.md
# Bidirectional Prefetch Candidate Issuer

This block sits behind a second-level cache access-map lookup. For each demand access, the lookup returns two sets of candidate block offsets: one set above the accessed block and one set below it. This block turns those offsets into prefetch requests. It keeps the block-aligned base address, one candidate bitmap for each direction and one pending count for each direction. It then drains them, one candidate per direction per cycle. In each direction the lowest offset goes first.

Each selected candidate is handled in the same cycle. Its line address goes out on an access-map update strobe. The same address is presented to the demand miss table for a same-cycle lookup. If that lookup misses, a request goes to the prefetch miss table. A candidate is consumed once it is selected, even when the lookup suppresses its request. A new demand access replaces the whole batch. The access map and both miss tables are outside this block.

Top module: `pf_cand_issuer`

## Requirements
- R1: After a synchronous active-low reset, both bitmaps, both pending counts and the base are zero. With idle inputs no update strobe and no request is raised.
- R2: When `dmd_valid` is high at a clock edge, the base (the demand address with its low log2(BLK_BYTES) bits cleared), both bitmaps and both counts are replaced. Outputs in that same cycle still come from the previous batch. The new batch drives them from the next cycle.
- R3: In the upward direction, at most one candidate is selected per cycle. The selected candidate is the lowest set bit with index 1 or more, and its address is base + index × 64. Bit 0 is never selected, and a consumed bit is not selected again.
- R4: In the downward direction, at most one candidate is selected per cycle. The selected candidate is the lowest eligible set bit with index 1 or more, and its address is base − index × 64.
- R5: A downward bit is eligible only when base > index × 64 (strictly). A set bit that fails this test is never selected and does not block lower eligible bits.
- R6: A direction selects nothing while its pending count is zero. Each selection decrements the count by one. A direction also selects nothing when no selectable bit remains, whatever its count.
- R7: While `pmt_full` is high, neither direction selects, and the bitmaps and counts are held. Draining resumes with the same candidate afterwards.
- R8: A selected candidate always raises its update strobe. Its prefetch request is raised only when its demand-miss-table hit input is low. A suppressed candidate is still consumed.
- R9: While `pmt_almost_full` is high and the upward side raises a request, the downward side selects nothing and keeps its candidate. If the upward side raises no request, the downward side proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_valid | input | 1 | New demand access: load a fresh candidate batch |
| dmd_addr | input | ADDR_W | Demand byte address |
| dmd_fwd_map | input | MAP_BITS | Upward candidate offsets |
| dmd_bwd_map | input | MAP_BITS | Downward candidate offsets |
| dmd_fwd_cnt | input | CNT_W | Upward pending count |
| dmd_bwd_cnt | input | CNT_W | Downward pending count |
| pmt_full | input | 1 | Prefetch miss table has no free entry |
| pmt_almost_full | input | 1 | Prefetch miss table has exactly one free entry |
| fwd_upd_valid | output | 1 | Upward candidate selected: access-map update strobe |
| fwd_cand_addr | output | ADDR_W | Upward candidate line address (update and lookup address) |
| fwd_dmd_hit | input | 1 | Demand miss table matches `fwd_cand_addr` |
| fwd_pf_req | output | 1 | Upward prefetch request to the prefetch miss table |
| bwd_upd_valid | output | 1 | Downward candidate selected: access-map update strobe |
| bwd_cand_addr | output | ADDR_W | Downward candidate line address |
| bwd_dmd_hit | input | 1 | Demand miss table matches `bwd_cand_addr` |
| bwd_pf_req | output | 1 | Downward prefetch request to the prefetch miss table |

## Verification
A stale bit in a bitmap appears at the ports on the next cycle without a stall. It shows as a repeated or out-of-order candidate address, so every drain sequence is compared address by address. A wrong pending count shows as one candidate too many or too few at the end of a drain. A base that is not reloaded or not aligned offsets every following address, and this is visible in the first cycle after the load. Stall and priority errors are visible in the same cycle as a strobe raised against `pmt_full` or `pmt_almost_full`.

// File: rtl/pfi_pkg.sv
// Shared types for the prefetch candidate issuer.
// Assumes nothing beyond being compiled before the modules that import it.
package pfi_pkg;
    // Direction in which a lane walks away from the base block.
    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_BWD = 1'b1
    } pf_dir_e;
endpackage

// File: rtl/pfi_lowpick.sv
// Lowest-index set-bit finder.
// Returns whether any request bit is set and, if so, the index of the
// lowest one. Purely combinational; the caller masks out forbidden bits.
module pfi_lowpick #(
    parameter int N     = 128,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the last hit kept is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pfi_lane.sv
// One direction of the candidate issuer.
// Holds a candidate bitmap and a pending count. Each cycle it selects the
// lowest eligible offset and forms its line address from the shared base.
// Assumes: bit 0 is never a candidate. In the downward direction an offset
// must not reach or pass address zero. A load overrides consumption.
module pfi_lane
    import pfi_pkg::*;
#(
    parameter int      ADDR_W   = 26,
    parameter int      MAP_BITS = 128,
    parameter int      CNT_W    = 5,
    parameter int      LOG_BLK  = 6,
    parameter pf_dir_e DIR      = DIR_FWD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAP_BITS-1:0] map_in,
    input  logic [CNT_W-1:0]    cnt_in,
    input  logic [ADDR_W-1:0]   base,
    input  logic                stall,
    output logic                sel_valid,
    output logic [ADDR_W-1:0]   sel_addr
);
    localparam int IDX_W = $clog2(MAP_BITS);
    localparam int OFF_W = IDX_W + LOG_BLK;
    localparam int CMP_W = ((ADDR_W > OFF_W) ? ADDR_W : OFF_W) + 1;

    logic [MAP_BITS-1:0] map_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [MAP_BITS-1:0] elig;
    logic                found;
    logic [IDX_W-1:0]    idx;
    logic [OFF_W-1:0]    off;

    // Eligibility mask: drop bit 0, and for the downward lane drop offsets
    // that would reach or pass address zero.
    for (genvar g = 0; g < MAP_BITS; g++) begin : g_elig
        if (g == 0) begin : g_zero
            assign elig[g] = 1'b0;
        end else if (DIR == DIR_BWD) begin : g_down
            localparam logic [CMP_W-1:0] LIM = CMP_W'(g) << LOG_BLK;
            assign elig[g] = map_q[g] && (CMP_W'(base) > LIM);
        end else begin : g_up
            assign elig[g] = map_q[g];
        end
    end

    pfi_lowpick #(.N(MAP_BITS), .IDX_W(IDX_W)) u_pick (
        .req  (elig),
        .found(found),
        .idx  (idx)
    );

    // Selection qualifier and line-address arithmetic.
    always_comb begin
        off       = {idx, {LOG_BLK{1'b0}}};
        sel_valid = found && (cnt_q != '0) && !stall;
        if (DIR == DIR_FWD) begin
            sel_addr = base + ADDR_W'(off);
        end else begin
            sel_addr = base - ADDR_W'(off);
        end
    end

    // Bitmap and count: load a new batch or consume the selected candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            map_q <= map_in;
            cnt_q <= cnt_in;
        end else if (sel_valid) begin
            map_q[idx] <= 1'b0;
            cnt_q      <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/pf_cand_issuer.sv
// Bidirectional prefetch candidate issuer, top level.
// Holds the block-aligned base of the last demand access and two lanes that
// drain upward and downward candidates. Each selected candidate raises an
// access-map update strobe. Its prefetch request is gated by a same-cycle
// demand-miss-table lookup.
// Assumes: the demand-miss-table hit inputs are combinational functions of
// the candidate addresses. One free entry (almost full) goes to the upward side.
module pf_cand_issuer
    import pfi_pkg::*;
#(
    parameter int ADDR_W    = 26,
    parameter int MAP_BITS  = 128,
    parameter int CNT_W     = 5,
    parameter int BLK_BYTES = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dmd_valid,
    input  logic [ADDR_W-1:0]   dmd_addr,
    input  logic [MAP_BITS-1:0] dmd_fwd_map,
    input  logic [MAP_BITS-1:0] dmd_bwd_map,
    input  logic [CNT_W-1:0]    dmd_fwd_cnt,
    input  logic [CNT_W-1:0]    dmd_bwd_cnt,
    input  logic                pmt_full,
    input  logic                pmt_almost_full,
    output logic                fwd_upd_valid,
    output logic [ADDR_W-1:0]   fwd_cand_addr,
    input  logic                fwd_dmd_hit,
    output logic                fwd_pf_req,
    output logic                bwd_upd_valid,
    output logic [ADDR_W-1:0]   bwd_cand_addr,
    input  logic                bwd_dmd_hit,
    output logic                bwd_pf_req
);
    localparam int                LOG_BLK  = $clog2(BLK_BYTES);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);

    logic [ADDR_W-1:0] base_q;
    logic              fwd_stall;
    logic              bwd_stall;

    // Base register: block-aligned address of the latest demand access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (dmd_valid) begin
            base_q <= dmd_addr & ~OFF_MASK;
        end
    end

    // Stall rules: full stops both sides; one free entry goes upward first.
    always_comb begin
        fwd_stall = pmt_full;
        bwd_stall = pmt_full || (pmt_almost_full && fwd_pf_req);
    end

    pfi_lane #(
        .ADDR_W(ADDR_W), .MAP_BITS(MAP_BITS), .CNT_W(CNT_W),
        .LOG_BLK(LOG_BLK), .DIR(DIR_FWD)
    ) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dmd_valid),
        .map_in   (dmd_fwd_map),
        .cnt_in   (dmd_fwd_cnt),
        .base     (base_q),
        .stall    (fwd_stall),
        .sel_valid(fwd_upd_valid),
        .sel_addr (fwd_cand_addr)
    );

    pfi_lane #(
        .ADDR_W(ADDR_W), .MAP_BITS(MAP_BITS), .CNT_W(CNT_W),
        .LOG_BLK(LOG_BLK), .DIR(DIR_BWD)
    ) u_bwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dmd_valid),
        .map_in   (dmd_bwd_map),
        .cnt_in   (dmd_bwd_cnt),
        .base     (base_q),
        .stall    (bwd_stall),
        .sel_valid(bwd_upd_valid),
        .sel_addr (bwd_cand_addr)
    );

    // Request filter: a demand-miss-table match suppresses the prefetch.
    always_comb begin
        fwd_pf_req = fwd_upd_valid && !fwd_dmd_hit;
        bwd_pf_req = bwd_upd_valid && !bwd_dmd_hit;
    end
endmodule

// File: rtl/pfi_checker.sv
// Port-level property checker for pf_cand_issuer, attached by bind.
// Assumes the top-level port names and parameters of pf_cand_issuer.
module pfi_checker #(
    parameter int ADDR_W  = 26,
    parameter int LOG_BLK = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dmd_valid,
    input logic              pmt_full,
    input logic              pmt_almost_full,
    input logic              fwd_upd_valid,
    input logic [ADDR_W-1:0] fwd_cand_addr,
    input logic              fwd_dmd_hit,
    input logic              fwd_pf_req,
    input logic              bwd_upd_valid,
    input logic [ADDR_W-1:0] bwd_cand_addr,
    input logic              bwd_dmd_hit,
    input logic              bwd_pf_req
);
    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmt_full |-> (!fwd_upd_valid && !bwd_upd_valid));

    // R8
    fwd_hit_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_dmd_hit |-> !fwd_pf_req);

    // R8
    bwd_hit_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bwd_dmd_hit |-> !bwd_pf_req);

    // R8
    req_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_pf_req |-> fwd_upd_valid) and (bwd_pf_req |-> bwd_upd_valid));

    // R9
    almost_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmt_almost_full && fwd_pf_req) |-> !bwd_upd_valid);

    // R3
    fwd_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_upd_valid && !dmd_valid) |=>
            !(fwd_upd_valid && (fwd_cand_addr == $past(fwd_cand_addr))));

    // R4
    bwd_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bwd_upd_valid && !dmd_valid) |=>
            !(bwd_upd_valid && (bwd_cand_addr == $past(bwd_cand_addr))));

    // R2
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_upd_valid |-> (fwd_cand_addr[LOG_BLK-1:0] == '0)) and
        (bwd_upd_valid |-> (bwd_cand_addr[LOG_BLK-1:0] == '0)));
endmodule

bind pf_cand_issuer pfi_checker #(
    .ADDR_W (ADDR_W),
    .LOG_BLK($clog2(BLK_BYTES))
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dmd_valid      (dmd_valid),
    .pmt_full       (pmt_full),
    .pmt_almost_full(pmt_almost_full),
    .fwd_upd_valid  (fwd_upd_valid),
    .fwd_cand_addr  (fwd_cand_addr),
    .fwd_dmd_hit    (fwd_dmd_hit),
    .fwd_pf_req     (fwd_pf_req),
    .bwd_upd_valid  (bwd_upd_valid),
    .bwd_cand_addr  (bwd_cand_addr),
    .bwd_dmd_hit    (bwd_dmd_hit),
    .bwd_pf_req     (bwd_pf_req)
);

// File: tb/tb_pf_cand_issuer.sv
`timescale 1ns/1ps
module tb_pf_cand_issuer;
    localparam int AW = 26;
    localparam int MB = 128;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dmd_valid = 1'b0;
    logic [AW-1:0] dmd_addr = '0;
    logic [MB-1:0] dmd_fwd_map = '0;
    logic [MB-1:0] dmd_bwd_map = '0;
    logic [CW-1:0] dmd_fwd_cnt = '0;
    logic [CW-1:0] dmd_bwd_cnt = '0;
    logic          pmt_full = 1'b0;
    logic          pmt_almost_full = 1'b0;
    logic          fwd_dmd_hit = 1'b0;
    logic          bwd_dmd_hit = 1'b0;
    logic          fwd_upd_valid, fwd_pf_req, bwd_upd_valid, bwd_pf_req;
    logic [AW-1:0] fwd_cand_addr, bwd_cand_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pf_cand_issuer #(.ADDR_W(AW), .MAP_BITS(MB), .CNT_W(CW), .BLK_BYTES(64)) dut (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .dmd_fwd_map(dmd_fwd_map), .dmd_bwd_map(dmd_bwd_map),
        .dmd_fwd_cnt(dmd_fwd_cnt), .dmd_bwd_cnt(dmd_bwd_cnt),
        .pmt_full(pmt_full), .pmt_almost_full(pmt_almost_full),
        .fwd_upd_valid(fwd_upd_valid), .fwd_cand_addr(fwd_cand_addr),
        .fwd_dmd_hit(fwd_dmd_hit), .fwd_pf_req(fwd_pf_req),
        .bwd_upd_valid(bwd_upd_valid), .bwd_cand_addr(bwd_cand_addr),
        .bwd_dmd_hit(bwd_dmd_hit), .bwd_pf_req(bwd_pf_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one cycle; return just after the falling edge.
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [MB-1:0] bits(input int a, input int b = -1,
                                           input int c = -1, input int d = -1);
        logic [MB-1:0] m = '0;
        if (a >= 0) m[a] = 1'b1;
        if (b >= 0) m[b] = 1'b1;
        if (c >= 0) m[c] = 1'b1;
        if (d >= 0) m[d] = 1'b1;
        return m;
    endfunction

    task automatic load(input logic [AW-1:0] a, input logic [MB-1:0] fm,
                        input logic [MB-1:0] bm, input int fc, input int bc);
        dmd_valid   = 1'b1;
        dmd_addr    = a;
        dmd_fwd_map = fm;
        dmd_bwd_map = bm;
        dmd_fwd_cnt = CW'(fc);
        dmd_bwd_cnt = CW'(bc);
        tick();
        dmd_valid = 1'b0;
        #0;
    endtask

    // Compare both sides: strobe, address (when strobed) and request.
    task automatic expect_out(input string tag,
                              input logic fv, input logic [AW-1:0] fa, input logic fr,
                              input logic bv, input logic [AW-1:0] ba, input logic br);
        chk({tag, " fwd_upd_valid"}, 64'(fwd_upd_valid), 64'(fv));
        if (fv) chk({tag, " fwd_cand_addr"}, 64'(fwd_cand_addr), 64'(fa));
        chk({tag, " fwd_pf_req"}, 64'(fwd_pf_req), 64'(fr));
        chk({tag, " bwd_upd_valid"}, 64'(bwd_upd_valid), 64'(bv));
        if (bv) chk({tag, " bwd_cand_addr"}, 64'(bwd_cand_addr), 64'(ba));
        chk({tag, " bwd_pf_req"}, 64'(bwd_pf_req), 64'(br));
    endtask

    task automatic test_reset();
        expect_out("R1 idle after reset", 0, '0, 0, 0, '0, 0);
        tick();
        expect_out("R1 still idle", 0, '0, 0, 0, '0, 0);
    endtask

    task automatic test_fwd_drain();
        // base 0x12340; bit 0 ignored; count 2 leaves bit 9 unissued
        load(26'h12345, bits(0, 2, 5, 9), '0, 2, 0);
        expect_out("R3 fwd idx2", 1, 26'h123C0, 1, 0, '0, 0);
        tick();
        expect_out("R3 fwd idx5", 1, 26'h12480, 1, 0, '0, 0);
        tick();
        expect_out("R6 fwd count zero", 0, '0, 0, 0, '0, 0);
        tick();
        expect_out("R6 fwd stays idle", 0, '0, 0, 0, '0, 0);
    endtask

    task automatic test_fwd_exhaust();
        load(26'h2000, bits(0, 1), '0, 10, 0);
        expect_out("R3 fwd idx1", 1, 26'h2040, 1, 0, '0, 0);
        tick();
        expect_out("R6 R3 no bits left, bit0 ignored", 0, '0, 0, 0, '0, 0);
    endtask

    task automatic test_bwd_drain();
        load(26'h1000, '0, bits(1, 3), 0, 2);
        expect_out("R4 bwd idx1", 0, '0, 0, 1, 26'hFC0, 1);
        tick();
        expect_out("R4 bwd idx3", 0, '0, 0, 1, 26'hF40, 1);
        tick();
        expect_out("R4 bwd done", 0, '0, 0, 0, '0, 0);
    endtask

    task automatic test_bwd_limit();
        // base 0x100: idx3 -> 0x40 ok; idx4 equals base, idx5 past it
        load(26'h100, '0, bits(3, 4, 5), 0, 3);
        expect_out("R5 bwd idx3 eligible", 0, '0, 0, 1, 26'h40, 1);
        tick();
        expect_out("R5 idx4 not strictly below", 0, '0, 0, 0, '0, 0);
        tick();
        expect_out("R5 ineligible bits stay idle", 0, '0, 0, 0, '0, 0);
    endtask

    task automatic test_full();
        load(26'h4000, bits(4), '0, 1, 0);
        pmt_full = 1'b1;
        #1;
        expect_out("R7 full stalls", 0, '0, 0, 0, '0, 0);
        tick();
        expect_out("R7 full still stalls", 0, '0, 0, 0, '0, 0);
        pmt_full = 1'b0;
        #1;
        expect_out("R7 resume same candidate", 1, 26'h4100, 1, 0, '0, 0);
        tick();
        expect_out("R7 consumed after resume", 0, '0, 0, 0, '0, 0);
    endtask

    task automatic test_hit();
        load(26'h8000, bits(1, 2), '0, 2, 0);
        fwd_dmd_hit = 1'b1;
        #1;
        expect_out("R8 hit strobes without request", 1, 26'h8040, 0, 0, '0, 0);
        tick();
        fwd_dmd_hit = 1'b0;
        #1;
        expect_out("R8 suppressed candidate consumed", 1, 26'h8080, 1, 0, '0, 0);
        tick();
        expect_out("R8 drain done", 0, '0, 0, 0, '0, 0);
    endtask

    task automatic test_almost_full();
        load(26'h1000, bits(1), bits(1), 1, 1);
        pmt_almost_full = 1'b1;
        #1;
        expect_out("R9 fwd takes last entry", 1, 26'h1040, 1, 0, '0, 0);
        tick();
        expect_out("R9 bwd follows", 0, '0, 0, 1, 26'hFC0, 1);
        tick();
        // Upward candidate suppressed by a hit: downward may go alongside
        load(26'h1000, bits(1), bits(1), 1, 1);
        fwd_dmd_hit = 1'b1;
        #1;
        expect_out("R9 bwd proceeds when fwd not requesting",
                   1, 26'h1040, 0, 1, 26'hFC0, 1);
        tick();
        fwd_dmd_hit     = 1'b0;
        pmt_almost_full = 1'b0;
        #1;
        expect_out("R9 both drained", 0, '0, 0, 0, '0, 0);
    endtask

    task automatic test_reload();
        load(26'h3000, bits(1, 2), '0, 2, 0);
        expect_out("R2 first batch idx1", 1, 26'h3040, 1, 0, '0, 0);
        tick();
        dmd_valid   = 1'b1;
        dmd_addr    = 26'h5005;
        dmd_fwd_map = bits(3);
        dmd_fwd_cnt = CW'(1);
        #1;
        expect_out("R2 load cycle shows old batch", 1, 26'h3080, 1, 0, '0, 0);
        tick();
        dmd_valid = 1'b0;
        #1;
        expect_out("R2 new aligned base", 1, 26'h50C0, 1, 0, '0, 0);
        tick();
        expect_out("R2 old batch discarded", 0, '0, 0, 0, '0, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_fwd_drain();
        test_fwd_exhaust();
        test_bwd_drain();
        test_bwd_limit();
        test_full();
        test_hit();
        test_almost_full();
        test_reload();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule